// File: doc/BRIEF.md
# SDRAM Full-Page Burst Read Sequencer

This block runs one full-page burst read on a x16 SDRAM for a simple requester. A requester gives a bank, a row, a start column and a word count, then pulses `start`. The block opens the row with ACTIVE and waits out the row-to-column delay with NOPs. It then issues READ at the start column. After the CAS latency it captures each word from the data bus. Each captured word goes to the requester with a one-cycle valid strobe.

A full-page burst wraps around inside the open row and never ends by itself. The block therefore counts cycles from the READ and issues BURST TERMINATE at the cycle that lets exactly the requested number of words out of the device. It then pulses `done` together with the last word. It issues no PRECHARGE and applies no precharge wait, so the row stays open. Initialisation, refresh, precharge scheduling and writes belong to other logic.

The row-to-column delay is a parameter in picoseconds and is turned into a clock count with a ceiling division. The CAS latency may be 2 (the default) or 3.

Top module: `sdram_page_reader`

## Requirements
- R1: Commands are driven on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} as NOP = 4'b0111, ACTIVE = 4'b0011, READ = 4'b0101 and BURST TERMINATE = 4'b0110. In the cycle after an accepted `start`, ACTIVE is on the bus with the requested row on `sd_addr` and the requested bank on `sd_ba`.
- R2: READ is on the bus exactly RCD cycles after the ACTIVE cycle, with NOP in between, where RCD = ceil(TRCD_PS / CLK_PS) and is at least 1.
- R3: With READ, `sd_addr[7:0]` carries the start column, `sd_addr[11:8]` is zero (this includes A10, so there is no auto-precharge), and `sd_ba` carries the bank.
- R4: BURST TERMINATE is on the bus exactly N cycles after the READ cycle, where N is the effective word count. This is CAS latency minus one cycles before the last wanted word appears. It is issued once per burst.
- R5: Counting the READ cycle as cycle 0, word k is taken from `sd_dq` in cycle CL+k. It appears on `rd_data` with `rd_valid` high in the next cycle. Exactly N words are flagged, the column wraps from 255 to 0, and data still on the bus after the last wanted word is never flagged.
- R6: The effective count N equals `req_count` for values 1 to 256. A count of 0 gives N = 1, and a count above 256 gives N = 256.
- R7: `sd_dqm` is 2'b00 in every cycle from ACTIVE until the last word has been captured, and 2'b11 while the block is idle.
- R8: `done` is high for exactly one cycle, in the same cycle as the last `rd_valid`. The block never drives any command other than the four listed in R1, so no PRECHARGE is issued.
- R9: A `start` that arrives between acceptance and `done` is ignored. No second ACTIVE appears, and the words, row, column and count of the running burst are unchanged.
- R10: After reset the bus shows NOP, `sd_dqm` is 2'b11, and `rd_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a burst (sampled while idle) |
| req_bank | input | 2 | Bank to read |
| req_row | input | 12 | Row to open |
| req_col | input | 8 | First column of the burst |
| req_count | input | 9 | Words wanted (clipped to 1..256) |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | 2 | SDRAM bank address |
| sd_addr | output | 12 | SDRAM address bus |
| sd_dqm | output | 2 | Byte masks, low while reading |
| sd_dq | input | 16 | Data from the SDRAM |
| rd_data | output | 16 | Captured word |
| rd_valid | output | 1 | `rd_data` holds a wanted word |
| done | output | 1 | One-cycle pulse with the final word |

## Verification
The bench pairs the block with a behavioural memory model. The model returns a word pattern derived from the row and column for as long as the burst runs, and puts a marker value on the bus otherwise. A short mid-row burst checks the ACTIVE-to-READ spacing, the address fields and the terminate cycle without wrap-around. A burst that starts near column 255 shows whether the column wraps to 0. Single-word and zero-count requests test the case where the terminate follows the READ directly. Requests of 256 and 300 words tell exact counting apart from clipping. A start pulse injected mid-burst with different fields shows whether the running burst can be disturbed.

// File: rtl/sdram_page_reader.sv
module sdram_page_reader #(
  parameter int CL      = 2,
  parameter int CLK_PS  = 20000,
  parameter int TRCD_PS = 20000,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int BANK_W  = 2,
  parameter int DQ_W    = 16,
  parameter int PAGE    = 256,
  parameter int CNT_W   = $clog2(PAGE) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [CNT_W-1:0]  req_count,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [DQ_W/8-1:0] sd_dqm,
  input  logic [DQ_W-1:0]   sd_dq,
  output logic [DQ_W-1:0]   rd_data,
  output logic              rd_valid,
  output logic              done
);
  localparam int RCD_RAW = (TRCD_PS + CLK_PS - 1) / CLK_PS;
  localparam int RCD     = (RCD_RAW < 1) ? 1 : RCD_RAW;
  localparam int RW      = $clog2(RCD + 1) + 1;
  localparam int PC_W    = $clog2(PAGE + CL + 1) + 1;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_BT  = 4'b0110;

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_WAIT, S_RD, S_STREAM} st_t;
  st_t st;

  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [PC_W-1:0]   n_q, pc, n_eff;
  logic [RW-1:0]     wcnt;
  logic [3:0]        cmd;
  logic              in_win, last_w;

  assign n_eff = (req_count == '0) ? PC_W'(1) :
                 (req_count > CNT_W'(PAGE)) ? PC_W'(PAGE) : PC_W'(req_count);

  assign in_win = (pc >= PC_W'(CL)) && (pc < n_q + PC_W'(CL));
  assign last_w = (pc == n_q + PC_W'(CL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bank_q   <= '0;
      row_q    <= '0;
      col_q    <= '0;
      n_q      <= '0;
      pc       <= '0;
      wcnt     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          bank_q <= req_bank;
          row_q  <= req_row;
          col_q  <= req_col;
          n_q    <= n_eff;
          st     <= S_ACT;
        end
        S_ACT: begin
          wcnt <= RW'(1);
          st   <= (RCD == 1) ? S_RD : S_WAIT;
        end
        S_WAIT: begin
          if (wcnt == RW'(RCD - 1)) st <= S_RD;
          else wcnt <= wcnt + 1'b1;
        end
        S_RD: begin
          pc <= PC_W'(1);
          st <= S_STREAM;
        end
        S_STREAM: begin
          pc <= pc + 1'b1;
          if (in_win) begin
            rd_valid <= 1'b1;
            rd_data  <= sd_dq;
          end
          if (last_w) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd     = C_NOP;
    sd_addr = '0;
    sd_ba   = '0;
    case (st)
      S_ACT: begin
        cmd     = C_ACT;
        sd_addr = row_q;
        sd_ba   = bank_q;
      end
      S_RD: begin
        cmd     = C_RD;
        sd_addr = ROW_W'(col_q);
        sd_ba   = bank_q;
      end
      S_STREAM: if (pc == n_q) cmd = C_BT;
      default: ;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_dqm = (st == S_IDLE) ? '1 : '0;
endmodule

// File: rtl/sdram_page_reader_chk.sv
module sdram_page_reader_chk #(
  parameter int ROW_W = 12,
  parameter int COL_W = 8,
  parameter int DQM_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [ROW_W-1:0] sd_addr,
  input logic [DQM_W-1:0] sd_dqm,
  input logic             rd_valid,
  input logic             done
);
  logic [3:0] c;
  assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  AST_LEGAL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0111 || c == 4'b0011 || c == 4'b0101 || c == 4'b0110)); // R8
  AST_ACT_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0011) |=> (c == 4'b0111 || c == 4'b0101)); // R2
  AST_READ_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0101) |-> (sd_addr[ROW_W-1:COL_W] == '0)); // R3
  AST_SINGLE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0110) |=> (c != 4'b0110)); // R4
  AST_DONE_LAST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rd_valid); // R5
  AST_DQM_READING: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0101 || c == 4'b0110) |-> (sd_dqm == '0)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
endmodule

bind sdram_page_reader sdram_page_reader_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .DQM_W(DQ_W/8)) chk_i (
  .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
  .sd_dqm(sd_dqm), .rd_valid(rd_valid), .done(done));

// File: tb/sdram_page_reader_tb_top.sv
module sdram_page_reader_tb_top;
  localparam int CL = 2;
  localparam int CLK_PS = 20000;
  localparam int TRCD_PS = 20000;
  localparam int RCD = (TRCD_PS + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] req_bank = '0;
  logic [11:0] req_row = '0;
  logic [7:0] req_col = '0;
  logic [8:0] req_count = '0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba, sd_dqm;
  logic [11:0] sd_addr;
  logic [15:0] sd_dq = 16'hDEAD, rd_data;
  logic rd_valid, done;

  int checks = 0, fails = 0, cyc = 0;

  sdram_page_reader #(.CL(CL), .CLK_PS(CLK_PS), .TRCD_PS(TRCD_PS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_count(req_count),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
    .sd_dq(sd_dq), .rd_data(rd_data), .rd_valid(rd_valid), .done(done));

  always #10ns clk = ~clk;

  function automatic logic [15:0] pat(logic [1:0] b, logic [11:0] r, logic [7:0] c);
    return {r[7:0], c} ^ {b, 14'h0};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor and memory model state
  int n_act, act_cyc, rd_cyc, bt_cyc, n_bt, bad_cmd, dqm_bad, n_done, done_cyc, nget, last_valid_cyc;
  logic [11:0] act_addr, rd_addr;
  logic [1:0] act_ba, rd_ba;
  logic rd_seen, bt_seen, in_burst;
  logic [15:0] got [0:299];

  always @(posedge clk) cyc++;

  always @(negedge clk) if (rst_n) begin
    case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
      4'b0111: ;
      4'b0011: begin n_act++; act_cyc = cyc; act_addr = sd_addr; act_ba = sd_ba; end
      4'b0101: begin rd_seen = 1'b1; bt_seen = 1'b0; rd_cyc = cyc; rd_addr = sd_addr; rd_ba = sd_ba; end
      4'b0110: begin n_bt++; if (!bt_seen) bt_cyc = cyc; bt_seen = 1'b1; end
      default: bad_cmd++;
    endcase
    if (done) begin in_burst = 1'b0; n_done++; done_cyc = cyc; end
    if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011) in_burst = 1'b1;
    if (in_burst && sd_dqm != 2'b00) dqm_bad++;
    if (rd_valid) begin
      if (nget < 300) got[nget] = rd_data;
      nget++;
      last_valid_cyc = cyc;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rd_seen && cyc >= rd_cyc + CL && (!bt_seen || cyc <= bt_cyc + CL - 1))
      sd_dq = pat(act_ba, act_addr, 8'(rd_addr[7:0] + 8'(cyc - rd_cyc - CL)));
    else
      sd_dq = 16'hDEAD;
  end

  task automatic run(logic [1:0] b, logic [11:0] r, logic [7:0] c, logic [8:0] cnt, int expn, bit inject);
    int mism = 0;
    int waited = 0;
    @(negedge clk);
    n_act = 0; n_bt = 0; bad_cmd = 0; dqm_bad = 0; n_done = 0; nget = 0;
    rd_seen = 1'b0; bt_seen = 1'b0; in_burst = 1'b0;
    act_cyc = -1; rd_cyc = -1; bt_cyc = -1; done_cyc = -1; last_valid_cyc = -1;
    start = 1'b1; req_bank = b; req_row = r; req_col = c; req_count = cnt;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (3) @(negedge clk);
      start = 1'b1; req_bank = ~b; req_row = ~r; req_col = ~c; req_count = 9'd7;
      @(negedge clk);
      start = 1'b0;
    end
    while (n_done == 0 && waited < 700) begin @(negedge clk); waited++; end
    repeat (CL + 3) @(negedge clk);
    check(n_act == 1, "R9", "ACTIVE count", n_act, 1);
    check(act_addr == r && act_ba == b, "R1", "ACTIVE row/bank", int'(act_addr), int'(r));
    check(rd_cyc - act_cyc == RCD, "R2", "ACTIVE->READ cycles", rd_cyc - act_cyc, RCD);
    check(rd_addr == {4'b0, c} && rd_ba == b, "R3", "READ address", int'(rd_addr), int'(c));
    check(n_bt == 1 && bt_cyc - rd_cyc == expn, "R4", "READ->TERMINATE cycles", bt_cyc - rd_cyc, expn);
    check(nget == expn, "R6", "word count", nget, expn);
    for (int k = 0; k < expn && k < nget && k < 300; k++)
      if (got[k] !== pat(b, r, 8'(c + k))) mism++;
    check(mism == 0, "R5", "word mismatches", mism, 0);
    check(last_valid_cyc == rd_cyc + CL + expn, "R5", "last word cycle", last_valid_cyc - rd_cyc, CL + expn);
    check(n_done == 1 && done_cyc == last_valid_cyc, "R8", "done pulse cycle", done_cyc - rd_cyc, CL + expn);
    check(bad_cmd == 0, "R8", "illegal commands", bad_cmd, 0);
    check(dqm_bad == 0 && sd_dqm == 2'b11, "R7", "DQM errors", dqm_bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R10", "reset command",
          int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
    check(sd_dqm == 2'b11, "R10", "reset DQM", int'(sd_dqm), 3);
    check(!rd_valid && !done, "R10", "reset valid/done", int'({rd_valid, done}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(2'd1, 12'h3A5, 8'h10, 9'd4, 4, 1'b0);     // basic
    run(2'd2, 12'h0FF, 8'd250, 9'd12, 12, 1'b0);  // R5 wrap
    run(2'd3, 12'h001, 8'd77, 9'd1, 1, 1'b0);     // single word
    run(2'd0, 12'h456, 8'd9, 9'd0, 1, 1'b0);      // R6 zero count
    run(2'd1, 12'h777, 8'd0, 9'd256, 256, 1'b0);  // full page
    run(2'd2, 12'h0AB, 8'd5, 9'd300, 256, 1'b0);  // R6 clip
    run(2'd0, 12'h135, 8'd40, 9'd20, 20, 1'b1);   // R9 busy start
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule